// File: doc/BRIEF.md
# Scheduled Chunk Transport Sequencer

This block moves fixed-width data chunks out of a producer-side output buffer and onto a channel with a fixed latency. The channel can carry up to K chunks in one cycle. No handshake or queue controls the moves. A precomputed schedule table sets them instead: each table entry holds a buffer address and a cycle offset. A start pulse marks the fire time of a transfer. From that pulse, an internal cycle counter runs. On every cycle the sequencer reads the buffer for each entry that is due and puts the chunk straight onto a lane. The sequencer has no storage of its own, so a chunk goes from the buffer read onto a lane. A register pipeline then models the wire delay.

The producer writes chunks into the output buffer through a simple write port. Software or a configuration engine fills the schedule table and gives the entry count with the start pulse. The block also watches whether the schedule is honoured. It raises a sticky flag when a scheduled read finds an address that has not been written. It raises another sticky flag when an entry has to go out later than its offset, either because more than K entries share a cycle or because offsets decrease along the table.

Top module: `chunk_xfer_seq`

## Requirements
- R1: After reset, every lane valid, the done output and both error flags are low.
- R2: When start is sampled high at clock edge S, the entry with offset o is read at edge S+o+1 and appears on a lane after edge S+o+1+WIRE_DLY. Its lane address and lane data are the chunk most recently written at that buffer address.
- R3: Entries that are due in the same cycle go onto lanes 0, 1, 2 and upward in table order. At most K of them go out per cycle.
- R4: An entry that cannot go out in its own cycle still goes out on the first later cycle with a free lane. Examples are the (K+1)-th entry sharing an offset, or an entry whose offset is below the counter. Such an entry sets the late error flag one edge after it is issued.
- R5: A scheduled read of a buffer address that has never been written leaves that lane's valid low at the output. It sets the unwritten error flag on the read edge. The other lanes of the same cycle are unaffected.
- R6: A chunk can only be sent in a cycle strictly after its write. A buffer write and a scheduled read of the same address on the same edge count as a read of unwritten data, as in R5. A read on any later edge returns the new data.
- R7: The done output pulses high for one cycle, in the same cycle as the last scheduled chunk's output slot. With an entry count of 0, done pulses after edge S+1+WIRE_DLY.
- R8: Both error flags hold until the next start pulse. On the edge that samples start, both flags clear.
- R9: No lane is valid except in the output slot of a scheduled entry. In particular, nothing is sent before start or after the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_we | input | 1 | Output buffer write enable |
| buf_waddr | input | AW | Output buffer write address |
| buf_wdata | input | CHUNK_W | Chunk to write |
| tbl_we | input | 1 | Schedule table write enable |
| tbl_widx | input | IW | Table entry index to write |
| tbl_waddr | input | AW | Buffer address held by the entry |
| tbl_wofs | input | OFS_W | Cycle offset held by the entry |
| sched_len | input | IW+1 | Number of table entries, sampled with start |
| start | input | 1 | Fire-time pulse; restarts the counter at zero |
| lane_vld | output | K | Per-lane chunk valid after the wire delay |
| lane_addr | output | K*AW | Per-lane buffer address of the chunk |
| lane_data | output | K*CHUNK_W | Per-lane chunk data |
| xfer_done | output | 1 | One-cycle pulse with the final chunk's slot |
| err_late | output | 1 | Sticky: an entry went out after its offset |
| err_unwritten | output | 1 | Sticky: a scheduled read found no data |

## Verification
Two functions can meet in the same cycle: the producer writing into the buffer, and the sequencer's scheduled read of that same address. The bench arranges this by placing the write on exactly the edge that the table entry's offset selects. It then expects a quiet lane and a raised unwritten flag, and on the next transfer it expects the fresh data to go out normally. A second overlap comes from packing more than K entries into one offset: lane filling and late detection fall together. The bench judges that case by the lane order, the one-cycle slip of the surplus entry and the late flag.

// File: rtl/cxs_pkg.sv
package cxs_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  function automatic int idx_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/cxs_sched_table.sv
module cxs_sched_table #(
  parameter int DEPTH = 16,
  parameter int IW    = 4,
  parameter int AW    = 4,
  parameter int OW    = 8,
  parameter int K     = 2
) (
  input  logic            clk,
  input  logic            we,
  input  logic [IW-1:0]   widx,
  input  logic [AW-1:0]   waddr,
  input  logic [OW-1:0]   wofs,
  input  logic [K*IW-1:0] ridx,
  output logic [K*AW-1:0] raddr,
  output logic [K*OW-1:0] rofs
);

  logic [AW-1:0] addr_mem [DEPTH];
  logic [OW-1:0] ofs_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      addr_mem[widx] <= waddr;
      ofs_mem[widx]  <= wofs;
    end
  end

  for (genvar j = 0; j < K; j++) begin : g_rd
    assign raddr[j*AW +: AW] = addr_mem[ridx[j*IW +: IW]];
    assign rofs[j*OW +: OW]  = ofs_mem[ridx[j*IW +: IW]];
  end

endmodule

// File: rtl/cxs_issue.sv
module cxs_issue
  import cxs_pkg::*;
#(
  parameter int IW = 4,
  parameter int AW = 4,
  parameter int OW = 8,
  parameter int K  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [IW:0]     sched_len,
  output logic [K*IW-1:0] ridx,
  input  logic [K*AW-1:0] raddr,
  input  logic [K*OW-1:0] rofs,
  output logic [K-1:0]    iss_vld,
  output logic [K*AW-1:0] iss_addr,
  output logic            iss_fin,
  output logic            iss_late,
  output logic            running
);

  localparam logic [OW-1:0] CNT_MAX = {OW{1'b1}};

  seq_state_e  state_q;
  logic [OW-1:0] cnt_q;
  logic [IW:0]   ptr_q;
  logic [IW:0]   len_q;
  logic [IW:0]   n_iss;

  assign running = (state_q == SEQ_RUN);
  assign iss_addr = raddr;

  always_comb begin : c_window
    logic        ok_prev;
    logic [IW:0] idx;
    logic [OW-1:0] ofs;
    ok_prev  = running;
    n_iss    = '0;
    iss_late = 1'b0;
    iss_vld  = '0;
    ridx     = '0;
    for (int j = 0; j < K; j++) begin
      idx = ptr_q + (IW+1)'(j);
      ridx[j*IW +: IW] = idx[IW-1:0];
      ofs = rofs[j*OW +: OW];
      iss_vld[j] = ok_prev && (idx < len_q) && (ofs <= cnt_q);
      if (iss_vld[j]) begin
        n_iss = n_iss + 1'b1;
        if (ofs < cnt_q) iss_late = 1'b1;
      end
      ok_prev = iss_vld[j];
    end
    iss_fin = running && ((ptr_q + n_iss) == len_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      ptr_q   <= '0;
      len_q   <= '0;
    end else if (start) begin
      state_q <= SEQ_RUN;
      cnt_q   <= '0;
      ptr_q   <= '0;
      len_q   <= sched_len;
    end else if (running) begin
      ptr_q <= ptr_q + n_iss;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (iss_fin) state_q <= SEQ_IDLE;
    end
  end

endmodule

// File: rtl/cxs_outbuf.sv
module cxs_outbuf #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 256,
  parameter int K     = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [CW-1:0]   wdata,
  input  logic [K-1:0]    rd_req,
  input  logic [K*AW-1:0] rd_addr,
  output logic [K-1:0]    rd_vld,
  output logic [K*AW-1:0] rd_addr_q,
  output logic [K*CW-1:0] rd_data,
  output logic [K-1:0]    rd_miss
);

  logic [CW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] written_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) written_q <= '0;
    else if (we) written_q[waddr] <= 1'b1;
  end

  for (genvar j = 0; j < K; j++) begin : g_port
    logic [AW-1:0] a;
    assign a = rd_addr[j*AW +: AW];
    assign rd_miss[j] = rd_req[j] && !written_q[a];

    always_ff @(posedge clk) begin
      rd_data[j*CW +: CW] <= mem[a];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_vld[j]            <= 1'b0;
        rd_addr_q[j*AW +: AW] <= '0;
      end else begin
        rd_vld[j]            <= rd_req[j] && written_q[a];
        rd_addr_q[j*AW +: AW] <= a;
      end
    end
  end

endmodule

// File: rtl/cxs_pipe.sv
module cxs_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 3,
  parameter bit RESET  = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  if (RESET) begin : g_rst
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < STAGES; s++) st[s] <= '0;
      end else begin
        st[0] <= d;
        for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
      end
    end
  end else begin : g_norst
    always_ff @(posedge clk) begin
      st[0] <= d;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/chunk_xfer_seq.sv
module chunk_xfer_seq #(
  parameter int K         = 2,
  parameter int CHUNK_W   = 256,
  parameter int BUF_DEPTH = 16,
  parameter int TBL_DEPTH = 16,
  parameter int OFS_W     = 8,
  parameter int WIRE_DLY  = 3,
  localparam int AW = cxs_pkg::idx_bits(BUF_DEPTH),
  localparam int IW = cxs_pkg::idx_bits(TBL_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 buf_we,
  input  logic [AW-1:0]        buf_waddr,
  input  logic [CHUNK_W-1:0]   buf_wdata,
  input  logic                 tbl_we,
  input  logic [IW-1:0]        tbl_widx,
  input  logic [AW-1:0]        tbl_waddr,
  input  logic [OFS_W-1:0]     tbl_wofs,
  input  logic [IW:0]          sched_len,
  input  logic                 start,
  output logic [K-1:0]         lane_vld,
  output logic [K*AW-1:0]      lane_addr,
  output logic [K*CHUNK_W-1:0] lane_data,
  output logic                 xfer_done,
  output logic                 err_late,
  output logic                 err_unwritten
);

  localparam int CTRL_W = K + 1;
  localparam int DATA_W = K * (AW + CHUNK_W);

  logic [K*IW-1:0]      tbl_ridx;
  logic [K*AW-1:0]      tbl_raddr;
  logic [K*OFS_W-1:0]   tbl_rofs;
  logic [K-1:0]         iss_vld;
  logic [K*AW-1:0]      iss_addr;
  logic                 iss_fin;
  logic                 iss_late;
  logic                 running;
  logic [K-1:0]         rd_vld;
  logic [K*AW-1:0]      rd_addr_q;
  logic [K*CHUNK_W-1:0] rd_data;
  logic [K-1:0]         rd_miss;
  logic                 fin_q;
  logic [CTRL_W-1:0]    ctrl_out;
  logic [DATA_W-1:0]    data_out;

  cxs_sched_table #(
    .DEPTH(TBL_DEPTH), .IW(IW), .AW(AW), .OW(OFS_W), .K(K)
  ) i_table (
    .clk   (clk),
    .we    (tbl_we),
    .widx  (tbl_widx),
    .waddr (tbl_waddr),
    .wofs  (tbl_wofs),
    .ridx  (tbl_ridx),
    .raddr (tbl_raddr),
    .rofs  (tbl_rofs)
  );

  cxs_issue #(
    .IW(IW), .AW(AW), .OW(OFS_W), .K(K)
  ) i_issue (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .sched_len (sched_len),
    .ridx      (tbl_ridx),
    .raddr     (tbl_raddr),
    .rofs      (tbl_rofs),
    .iss_vld   (iss_vld),
    .iss_addr  (iss_addr),
    .iss_fin   (iss_fin),
    .iss_late  (iss_late),
    .running   (running)
  );

  cxs_outbuf #(
    .DEPTH(BUF_DEPTH), .AW(AW), .CW(CHUNK_W), .K(K)
  ) i_outbuf (
    .clk       (clk),
    .rst       (rst),
    .we        (buf_we),
    .waddr     (buf_waddr),
    .wdata     (buf_wdata),
    .rd_req    (iss_vld),
    .rd_addr   (iss_addr),
    .rd_vld    (rd_vld),
    .rd_addr_q (rd_addr_q),
    .rd_data   (rd_data),
    .rd_miss   (rd_miss)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fin_q         <= 1'b0;
      err_late      <= 1'b0;
      err_unwritten <= 1'b0;
    end else begin
      fin_q <= iss_fin;
      if (start) begin
        err_late      <= 1'b0;
        err_unwritten <= 1'b0;
      end else begin
        if (iss_late)  err_late      <= 1'b1;
        if (|rd_miss)  err_unwritten <= 1'b1;
      end
    end
  end

  cxs_pipe #(.W(CTRL_W), .STAGES(WIRE_DLY), .RESET(1'b1)) i_wire_ctrl (
    .clk (clk),
    .rst (rst),
    .d   ({fin_q, rd_vld}),
    .q   (ctrl_out)
  );

  cxs_pipe #(.W(DATA_W), .STAGES(WIRE_DLY), .RESET(1'b0)) i_wire_data (
    .clk (clk),
    .rst (rst),
    .d   ({rd_addr_q, rd_data}),
    .q   (data_out)
  );

  assign lane_vld  = ctrl_out[K-1:0];
  assign xfer_done = ctrl_out[K];
  assign lane_addr = data_out[DATA_W-1 -: K*AW];
  assign lane_data = data_out[K*CHUNK_W-1:0];

endmodule

// File: rtl/cxs_checker.sv
module cxs_checker #(
  parameter int K = 2
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [K-1:0] iss_vld,
  input logic         iss_fin,
  input logic         running,
  input logic [K-1:0] rd_vld,
  input logic [K-1:0] rd_miss,
  input logic         err_late,
  input logic         err_unwritten
);

  for (genvar j = 0; j < K; j++) begin : g_lane
    if (j > 0) begin : g_ord
      AST_LANE_ORDER: assert property (@(posedge clk) disable iff (rst)
        iss_vld[j] |-> iss_vld[j-1]); // R3
    end
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (iss_vld[j] && !rd_miss[j]) |=> rd_vld[j]); // R2
    AST_MISS_NO_SEND: assert property (@(posedge clk) disable iff (rst)
      rd_miss[j] |=> !rd_vld[j]); // R5
  end

  AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
    !running |-> (iss_vld == '0)); // R9

  AST_FIN_STOPS: assert property (@(posedge clk) disable iff (rst)
    (iss_fin && !start) |=> !running); // R7

  AST_LATE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_late && !start) |=> err_late); // R8

  AST_UNWR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_unwritten && !start) |=> err_unwritten); // R8

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (!err_late && !err_unwritten)); // R8

endmodule

bind chunk_xfer_seq cxs_checker #(.K(K)) i_cxs_checker (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .iss_vld       (iss_vld),
  .iss_fin       (iss_fin),
  .running       (running),
  .rd_vld        (rd_vld),
  .rd_miss       (rd_miss),
  .err_late      (err_late),
  .err_unwritten (err_unwritten)
);

// File: tb/test_chunk_xfer_seq.sv
module test_chunk_xfer_seq;

  localparam int K  = 2;
  localparam int CW = 256;
  localparam int AW = 4;
  localparam int IW = 4;
  localparam int OW = 8;
  localparam int DLY = 3;
  localparam int LAT = 1 + DLY;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic buf_we = 1'b0;
  logic [AW-1:0] buf_waddr = '0;
  logic [CW-1:0] buf_wdata = '0;
  logic tbl_we = 1'b0;
  logic [IW-1:0] tbl_widx = '0;
  logic [AW-1:0] tbl_waddr = '0;
  logic [OW-1:0] tbl_wofs = '0;
  logic [IW:0] sched_len = '0;
  logic start = 1'b0;
  logic [K-1:0] lane_vld;
  logic [K*AW-1:0] lane_addr;
  logic [K*CW-1:0] lane_data;
  logic xfer_done, err_late, err_unwritten;

  always #4 clk = ~clk;

  chunk_xfer_seq #(
    .K(K), .CHUNK_W(CW), .BUF_DEPTH(16), .TBL_DEPTH(16), .OFS_W(OW), .WIRE_DLY(DLY)
  ) i_chunk_xfer_seq (
    .clk(clk), .rst(rst),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .tbl_we(tbl_we), .tbl_widx(tbl_widx), .tbl_waddr(tbl_waddr), .tbl_wofs(tbl_wofs),
    .sched_len(sched_len), .start(start),
    .lane_vld(lane_vld), .lane_addr(lane_addr), .lane_data(lane_data),
    .xfer_done(xfer_done), .err_late(err_late), .err_unwritten(err_unwritten)
  );

  typedef struct {
    int          cyc;
    int          lane;
    logic        vld;
    logic [AW-1:0] a;
    logic [CW-1:0] d;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   done_q[$];
  logic [CW-1:0] bm [16];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [CW-1:0] pat(input int a, input int g);
    logic [31:0] w;
    w = 32'h5A00_0000 + 32'(a) * 32'h0001_0101 + 32'(g) * 32'h0100_0000;
    return {8{w}};
  endfunction

  task automatic chk(input string req, input string what, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic buf_write(input int a, input int g);
    buf_we = 1'b1; buf_waddr = AW'(a); buf_wdata = pat(a, g);
    @(negedge clk);
    buf_we = 1'b0;
    bm[a] = pat(a, g);
  endtask

  task automatic tbl_load(input int idx, input int a, input int o);
    tbl_we = 1'b1; tbl_widx = IW'(idx); tbl_waddr = AW'(a); tbl_wofs = OW'(o);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic fire(input int len, output int s);
    s = cyc + 1;
    start = 1'b1; sched_len = (IW+1)'(len);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_lane(input int s, input int o, input int lane, input int a, input logic v, input string req);
    exp_t e;
    e.cyc = s + o + LAT; e.lane = lane; e.vld = v; e.a = AW'(a);
    e.d = v ? bm[a] : '0; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: compares lane outputs and done against the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      bit covered [K];
      for (int j = 0; j < K; j++) covered[j] = 1'b0;
      for (int i = exp_q.size() - 1; i >= 0; i--) begin
        if (exp_q[i].cyc == cyc) begin
          int l;
          l = exp_q[i].lane;
          covered[l] = 1'b1;
          chk(exp_q[i].req, "lane valid", CW'(lane_vld[l]), CW'(exp_q[i].vld));
          if (exp_q[i].vld) begin
            chk(exp_q[i].req, "lane addr", CW'(lane_addr[l*AW +: AW]), CW'(exp_q[i].a));
            chk(exp_q[i].req, "lane data", lane_data[l*CW +: CW], exp_q[i].d);
          end
          exp_q.delete(i);
        end else if (exp_q[i].cyc < cyc) begin
          chk(exp_q[i].req, "missed slot", CW'(0), CW'(1));
          exp_q.delete(i);
        end
      end
      for (int j = 0; j < K; j++)
        if (!covered[j] && lane_vld[j]) chk("R9", "unexpected lane valid", CW'(1), CW'(0));
      begin
        bit want;
        want = 1'b0;
        for (int i = done_q.size() - 1; i >= 0; i--)
          if (done_q[i] == cyc) begin want = 1'b1; done_q.delete(i); end
        if (want || xfer_done) chk("R7", "done pulse", CW'(xfer_done), CW'(want));
      end
    end
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "lane_vld", CW'(lane_vld), CW'(0));
    chk("R1", "done", CW'(xfer_done), CW'(0));
    chk("R1", "err_late", CW'(err_late), CW'(0));
    chk("R1", "err_unwritten", CW'(err_unwritten), CW'(0));
    mon_on = 1'b1;
    for (int a = 0; a < 8; a++) buf_write(a, 1);

    // R2/R3/R7: basic schedule, two entries sharing an offset
    tbl_load(0, 3, 0); tbl_load(1, 5, 2); tbl_load(2, 1, 2); tbl_load(3, 7, 5);
    repeat (2) @(negedge clk);
    fire(4, s);
    expect_lane(s, 0, 0, 3, 1'b1, "R2");
    expect_lane(s, 2, 0, 5, 1'b1, "R3");
    expect_lane(s, 2, 1, 1, 1'b1, "R3");
    expect_lane(s, 5, 0, 7, 1'b1, "R2");
    done_q.push_back(s + 5 + LAT);
    wait_until(s + 12);
    chk("R2", "no late flag", CW'(err_late), CW'(0));
    chk("R2", "no unwritten flag", CW'(err_unwritten), CW'(0));

    // R4: three entries at one offset with K=2, surplus slips a cycle
    tbl_load(0, 0, 1); tbl_load(1, 2, 1); tbl_load(2, 4, 1); tbl_load(3, 6, 4);
    fire(4, s);
    expect_lane(s, 1, 0, 0, 1'b1, "R4");
    expect_lane(s, 1, 1, 2, 1'b1, "R4");
    expect_lane(s, 2, 0, 4, 1'b1, "R4");
    expect_lane(s, 4, 0, 6, 1'b1, "R4");
    done_q.push_back(s + 4 + LAT);
    wait_until(s + 2);
    chk("R4", "late flag before slip", CW'(err_late), CW'(0));
    wait_until(s + 3);
    chk("R4", "late flag after slip", CW'(err_late), CW'(1));
    wait_until(s + 12);
    chk("R8", "late flag held", CW'(err_late), CW'(1));

    // R5/R6: unwritten read beside a good lane, and a same-edge write/read
    tbl_load(0, 9, 0); tbl_load(1, 2, 0); tbl_load(2, 10, 3);
    fire(3, s);
    chk("R8", "late flag cleared by start", CW'(err_late), CW'(0));
    expect_lane(s, 0, 0, 9, 1'b0, "R5");
    expect_lane(s, 0, 1, 2, 1'b1, "R5");
    expect_lane(s, 3, 0, 10, 1'b0, "R6");
    done_q.push_back(s + 3 + LAT);
    wait_until(s + 2);
    chk("R5", "unwritten flag", CW'(err_unwritten), CW'(1));
    wait_until(s + 3);
    buf_write(10, 2);   // sampled on the read edge s+4
    wait_until(s + 12);
    chk("R8", "unwritten flag held", CW'(err_unwritten), CW'(1));

    // R6: later read of the freshly written address succeeds
    tbl_load(0, 10, 0);
    fire(1, s);
    expect_lane(s, 0, 0, 10, 1'b1, "R6");
    done_q.push_back(s + LAT);
    wait_until(s + 10);
    chk("R8", "unwritten flag cleared", CW'(err_unwritten), CW'(0));

    // R7: empty schedule still pulses done
    fire(0, s);
    done_q.push_back(s + LAT);
    wait_until(s + 10);

    chk("R9", "scoreboard drained", CW'(exp_q.size() + done_q.size()), CW'(0));
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule